// File: doc/BRIEF.md
# Dual Oscillator Bitwise Combiner

This block runs two phase-accumulator oscillators. It merges their 10-bit values with a selectable Boolean operation, or with a plain average, and produces one signed 10-bit sample each time the sample strobe is high. Each oscillator has its own phase increment and its own waveform choice: square, triangle or saw. The increment is the wanted frequency in Hz multiplied by 2^32 divided by the sample rate. A controller outside the block works out that value from its user controls.

A third accumulator is only heard in the cascaded gating mode. In that mode all three oscillators are squares. The first square gates the second, and the gated result then gates the third. The result word is unsigned with a range of 0..1023. It is re-centred to the range -512..+511 and held in an output register until the next strobe.

Top module: `dual_osc_logic_mixer`

## Requirements
- R1: After reset the three phase accumulators and the output register hold zero, so sample_o reads 0 until the first strobe.
- R2: A phase accumulator adds its 32-bit increment only in a cycle where strobe_i is high, and it wraps modulo 2^32. Without a strobe, sample_o keeps its value whatever the other inputs do.
- R3: Wave code 2 (and the unused code 3) selects the saw, which is phase bits [31:22].
- R4: Wave code 0 selects the square, which is phase bit 31 copied into all ten bits (0x000 or 0x3FF).
- R5: Wave code 1 selects the triangle. It takes phase bits [30:21], inverted when phase bit 31 is set.
- R6: Operation codes 0 to 4 give OR, XOR, NOR, XNOR and NAND of the two oscillator values. Each result is masked to ten bits.
- R7: Operation code 5 gives the average: the 11-bit sum of the two values shifted right by one.
- R8: Operation code 6 is cascaded gating. All three oscillators become squares, and the result is square A AND square B AND square C. Oscillator C runs from inc_c_i.
- R9: Operation code 7 gives a result of zero.
- R10: sample_o equals the result minus 512 as a signed 10-bit value. The result is computed from the phases after the current strobe's update, and it is visible in the cycle after that strobe edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| strobe_i | input | 1 | Sample strobe; advances the accumulators and loads the output |
| inc_a_i | input | 32 | Phase increment, oscillator A |
| inc_b_i | input | 32 | Phase increment, oscillator B |
| inc_c_i | input | 32 | Phase increment, oscillator C (cascaded mode) |
| wave_a_i | input | 2 | Waveform code, oscillator A |
| wave_b_i | input | 2 | Waveform code, oscillator B |
| op_i | input | 3 | Combining operation code |
| sample_o | output | 10 | Signed output sample |

## Verification
Every result is due exactly one clock edge after the strobe that produces it, and it reflects the accumulators already advanced by that strobe. The bench raises the strobe at a falling edge, lowers it at the next falling edge, and checks sample_o there, half a period after the capturing rising edge. Hold behaviour is checked several idle cycles after the inputs are changed with no strobe. The reference keeps its own phase copies, advanced once per strobe.

// File: rtl/dobc_pkg.sv
package dobc_pkg;
  typedef enum logic [1:0] {
    WAVE_SQR = 2'd0,
    WAVE_TRI = 2'd1,
    WAVE_SAW = 2'd2,
    WAVE_SAW_ALT = 2'd3
  } wave_e;

  typedef enum logic [2:0] {
    OP_OR   = 3'd0,
    OP_XOR  = 3'd1,
    OP_NOR  = 3'd2,
    OP_XNOR = 3'd3,
    OP_NAND = 3'd4,
    OP_AVG  = 3'd5,
    OP_CASC = 3'd6,
    OP_ZERO = 3'd7
  } op_e;

  localparam int unsigned NUM_OSC = 3;
endpackage

// File: rtl/dobc_phase_acc.sv
module dobc_phase_acc #(
  parameter int unsigned ACC_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             strobe_i,
  input  logic [ACC_W-1:0] inc_i,
  output logic [ACC_W-1:0] phase_nxt_o
);
  logic [ACC_W-1:0] phase_q;

  assign phase_nxt_o = phase_q + inc_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       phase_q <= '0;
    else if (strobe_i) phase_q <= phase_nxt_o;
  end
endmodule

// File: rtl/dobc_wave_shaper.sv
module dobc_wave_shaper
  import dobc_pkg::*;
#(
  parameter int unsigned SMP_W = 10
) (
  input  logic [SMP_W:0]   top_i,   // top SMP_W+1 phase bits
  input  logic [1:0]       wave_i,
  output logic [SMP_W-1:0] val_o
);
  logic             msb;
  logic [SMP_W-1:0] below;

  assign msb   = top_i[SMP_W];
  assign below = top_i[SMP_W-1:0];

  always_comb begin
    unique case (wave_e'(wave_i))
      WAVE_SQR: val_o = {SMP_W{msb}};
      WAVE_TRI: val_o = msb ? ~below : below;
      default:  val_o = top_i[SMP_W -: SMP_W];
    endcase
  end
endmodule

// File: rtl/dobc_logic_combiner.sv
module dobc_logic_combiner
  import dobc_pkg::*;
#(
  parameter int unsigned SMP_W = 10
) (
  input  logic [2:0]       op_i,
  input  logic [SMP_W-1:0] a_i,
  input  logic [SMP_W-1:0] b_i,
  input  logic [SMP_W-1:0] c_i,
  output logic [SMP_W-1:0] res_o
);
  localparam logic [SMP_W-1:0] MASK = {SMP_W{1'b1}};

  logic [SMP_W:0] sum;
  assign sum = {1'b0, a_i} + {1'b0, b_i};

  always_comb begin
    unique case (op_e'(op_i))
      OP_OR:   res_o = a_i | b_i;
      OP_XOR:  res_o = a_i ^ b_i;
      OP_NOR:  res_o = ~(a_i | b_i) & MASK;
      OP_XNOR: res_o = ~(a_i ^ b_i) & MASK;
      OP_NAND: res_o = ~(a_i & b_i) & MASK;
      OP_AVG:  res_o = sum[SMP_W:1];
      OP_CASC: res_o = (a_i & b_i) & c_i;   // A gates B, that gates C
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/dual_osc_logic_mixer.sv
module dual_osc_logic_mixer
  import dobc_pkg::*;
#(
  parameter int unsigned ACC_W = 32,
  parameter int unsigned SMP_W = 10
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    strobe_i,
  input  logic [ACC_W-1:0]        inc_a_i,
  input  logic [ACC_W-1:0]        inc_b_i,
  input  logic [ACC_W-1:0]        inc_c_i,
  input  logic [1:0]              wave_a_i,
  input  logic [1:0]              wave_b_i,
  input  logic [2:0]              op_i,
  output logic signed [SMP_W-1:0] sample_o
);
  localparam int unsigned TOP = ACC_W - 1;

  logic [ACC_W-1:0] inc   [NUM_OSC];
  logic [1:0]       wave  [NUM_OSC];
  logic [ACC_W-1:0] nxt   [NUM_OSC];
  logic [SMP_W-1:0] val   [NUM_OSC];
  logic             casc;
  logic [SMP_W-1:0] res;

  assign casc    = (op_e'(op_i) == OP_CASC);
  assign inc[0]  = inc_a_i;
  assign inc[1]  = inc_b_i;
  assign inc[2]  = inc_c_i;
  assign wave[0] = casc ? WAVE_SQR : wave_a_i;
  assign wave[1] = casc ? WAVE_SQR : wave_b_i;
  assign wave[2] = WAVE_SQR;

  for (genvar g = 0; g < NUM_OSC; g++) begin : g_osc
    dobc_phase_acc #(.ACC_W(ACC_W)) u_acc (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .strobe_i   (strobe_i),
      .inc_i      (inc[g]),
      .phase_nxt_o(nxt[g])
    );
    dobc_wave_shaper #(.SMP_W(SMP_W)) u_shape (
      .top_i (nxt[g][TOP -: SMP_W+1]),
      .wave_i(wave[g]),
      .val_o (val[g])
    );
  end

  dobc_logic_combiner #(.SMP_W(SMP_W)) u_comb (
    .op_i (op_i),
    .a_i  (val[0]),
    .b_i  (val[1]),
    .c_i  (val[2]),
    .res_o(res)
  );

  // subtracting mid-scale flips the MSB
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sample_o <= '0;
    else if (strobe_i) sample_o <= $signed({~res[SMP_W-1], res[SMP_W-2:0]});
  end
endmodule

// File: rtl/dual_osc_logic_mixer_chk.sv
module dual_osc_logic_mixer_chk #(
  parameter int unsigned SMP_W = 10
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             strobe_i,
  input logic [1:0]       wave_a_i,
  input logic [1:0]       wave_b_i,
  input logic [2:0]       op_i,
  input logic [SMP_W-1:0] sample_o
);
  localparam logic [SMP_W-1:0] LO = {1'b1, {(SMP_W-1){1'b0}}};
  localparam logic [SMP_W-1:0] HI = {1'b0, {(SMP_W-1){1'b1}}};

  logic seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       seen_q <= 1'b0;
    else if (strobe_i) seen_q <= 1'b1;
  end

  p_idle_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seen_q |-> sample_o == '0);

  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_i |=> $stable(sample_o));

  p_sqr_or_rail_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && op_i == 3'd0 && wave_a_i == 2'd0 && wave_b_i == 2'd0)
    |=> (sample_o == LO || sample_o == HI));

  p_casc_rail_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && op_i == 3'd6) |=> (sample_o == LO || sample_o == HI));

  p_zero_op_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && op_i == 3'd7) |=> sample_o == LO);
endmodule

bind dual_osc_logic_mixer dual_osc_logic_mixer_chk #(.SMP_W(SMP_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .strobe_i(strobe_i),
  .wave_a_i(wave_a_i),
  .wave_b_i(wave_b_i),
  .op_i    (op_i),
  .sample_o(sample_o)
);

// File: tb/dual_osc_logic_mixer_tb.sv
module dual_osc_logic_mixer_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        strobe_i = 1'b0;
  logic [31:0] inc_a_i = '0, inc_b_i = '0, inc_c_i = '0;
  logic [1:0]  wave_a_i = '0, wave_b_i = '0;
  logic [2:0]  op_i = '0;
  logic signed [9:0] sample_o;

  int n_run = 0, n_fail = 0;
  logic [31:0] pa, pb, pc;

  always #4 clk_i = ~clk_i;

  dual_osc_logic_mixer u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .strobe_i(strobe_i),
    .inc_a_i(inc_a_i), .inc_b_i(inc_b_i), .inc_c_i(inc_c_i),
    .wave_a_i(wave_a_i), .wave_b_i(wave_b_i), .op_i(op_i),
    .sample_o(sample_o)
  );

  function automatic logic [9:0] shape(input logic [31:0] p, input logic [1:0] w);
    case (w)
      2'd0:    return p[31] ? 10'h3FF : 10'h000;
      2'd1:    return p[31] ? (10'h3FF - p[30:21]) : p[30:21];
      default: return p[31:22];
    endcase
  endfunction

  function automatic logic [9:0] model(input logic [2:0] op, input logic [1:0] wa,
                                       input logic [1:0] wb);
    logic [9:0] a, b, c, r;
    int s;
    a = shape(pa, (op == 3'd6) ? 2'd0 : wa);
    b = shape(pb, (op == 3'd6) ? 2'd0 : wb);
    c = shape(pc, 2'd0);
    case (op)
      3'd0: r = a | b;
      3'd1: r = a ^ b;
      3'd2: r = 10'h3FF - (a | b);
      3'd3: r = 10'h3FF - (a ^ b);
      3'd4: r = 10'h3FF - (a & b);
      3'd5: begin s = (int'(a) + int'(b)) / 2; r = s[9:0]; end
      3'd6: r = (a[9] & b[9] & c[9]) ? 10'h3FF : 10'h000;
      default: r = 10'h000;
    endcase
    s = int'(r) - 512;
    return s[9:0];
  endfunction

  function automatic string op_tag(input logic [2:0] op);
    if (op <= 3'd4) return "R6";
    if (op == 3'd5) return "R7";
    if (op == 3'd6) return "R8";
    return "R9";
  endfunction

  task automatic check(input string tag, input logic [9:0] exp);
    n_run++;
    if ($unsigned(sample_o) !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h (op %0d wa %0d wb %0d)",
               tag, $unsigned(sample_o), exp, op_i, wave_a_i, wave_b_i);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i) rst_ni = 1'b0;
    strobe_i = 1'b0;
    @(negedge clk_i) rst_ni = 1'b1;
    pa = '0; pb = '0; pc = '0;
  endtask

  // one strobe; result sampled at the following falling edge
  task automatic strobe_once();
    @(negedge clk_i) strobe_i = 1'b1;
    @(negedge clk_i) strobe_i = 1'b0;
    pa = pa + inc_a_i; pb = pb + inc_b_i; pc = pc + inc_c_i;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : main
    logic [9:0] held;
    do_reset();
    repeat (2) @(negedge clk_i);
    check("R1", 10'h000);
    // zero increments: accumulators still at zero
    op_i = 3'd0; wave_a_i = 2'd2; wave_b_i = 2'd2;
    strobe_once();
    check("R1", 10'h200);

    // single-oscillator waveforms: B stays at phase 0, saw gives 0
    for (int w = 0; w < 4; w++) begin
      do_reset();
      wave_a_i = w[1:0]; wave_b_i = 2'd2; op_i = 3'd0;
      inc_a_i = 32'h0712_3457; inc_b_i = '0;
      for (int k = 0; k < 80; k++) begin
        strobe_once();
        check(w == 0 ? "R4" : (w == 1 ? "R5" : "R3"), model(3'd0, w[1:0], 2'd2));
      end
    end

    // wrap: increment near 2^32
    do_reset();
    wave_a_i = 2'd2; inc_a_i = 32'hC000_0000; inc_b_i = '0;
    for (int k = 0; k < 6; k++) begin
      strobe_once();
      check("R2", model(3'd0, 2'd2, 2'd2));
    end

    // sweep over operations and waveform pairs
    for (int op = 0; op < 8; op++) begin
      for (int wa = 0; wa < 3; wa++) begin
        for (int wb = 0; wb < 3; wb++) begin
          op_i = op[2:0]; wave_a_i = wa[1:0]; wave_b_i = wb[1:0];
          inc_a_i = 32'h0531_7C11 + 32'(op * 32'h0100_3001) + 32'(wa * 32'h0020_0000);
          inc_b_i = 32'h0A93_0F07 + 32'(wb * 32'h0111_0000) + 32'(op * 32'h0007_1000);
          inc_c_i = 32'h1300_0101 + 32'(op * 32'h0210_0000);
          for (int k = 0; k < 24; k++) begin
            strobe_once();
            check(op_tag(op[2:0]), model(op[2:0], wa[1:0], wb[1:0]));
          end
        end
      end
    end

    // output register timing: stable without strobe
    held = $unsigned(sample_o);
    @(negedge clk_i);
    op_i = 3'd5; wave_a_i = 2'd1; inc_a_i = 32'h7FFF_0000; inc_b_i = 32'h1234_5678;
    repeat (5) @(negedge clk_i);
    check("R2", held);
    // accumulators did not move during the idle cycles
    strobe_once();
    check("R10", model(3'd5, 2'd1, wave_b_i));

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule